// File: doc/BRIEF.md
# Seven-Bit Reloadable Down Counter

This block is a small 7-bit counter that decrements on each qualified clock. On the clock after it reaches zero it reloads from a fixed period, so it can act as a cheap timer or clock divider that uses no wide arithmetic datapath. Counting is qualified twice. A hardware enable pin must be high, and a software enable bit must be set in an 8-bit control register that software writes through a simple write port.

A load pin can force the count back to the period value at any time. Two parameters decide whether the load pin and the enable pin are connected at all; a pin that is not connected is ignored. A mode parameter selects the form of the terminal-count output. In one mode it is combinational and is high while the count is zero. In the other mode it is registered, so it shows up one clock later, in the cycle where the count has just reloaded to the period.

Top module: `cnt7_down_counter`

## Requirements
- R1: When counting is qualified, the load pin is inactive and the count is not zero, the count decreases by exactly one on the next clock. The count is CNT_W bits wide and defaults to 7.
- R2: A synchronous active-high reset sets the count to INIT_VAL. It also clears the registered terminal-count output and clears the software enable bit, so the register reads back 0x00.
- R3: Counting is qualified only when the effective hardware enable is 1 and control-register bit 5 (mask 0x20) is 1. In any other clock without a load, the count holds.
- R4: When counting is qualified, the load pin is inactive and the count is zero, the next clock reloads the count to PERIOD. It does not wrap to all ones.
- R5: With ROUTE_LOAD=1, a high load pin sets the count to PERIOD on the next clock. This happens whether or not counting is qualified, and load takes priority over decrement and reload.
- R6: With ROUTE_LOAD=0, the load pin has no effect on the count or on the terminal-count output.
- R7: With ROUTE_EN=0, the hardware enable pin is ignored and only control-register bit 5 qualifies counting.
- R8: With ALT_MODE=1, the terminal-count output is high exactly while the count equals zero. It follows the count directly, whether or not counting is qualified.
- R9: With ALT_MODE=0, the terminal-count output is high for exactly one cycle after a clock that reloaded the count from zero, so it is seen while the count shows PERIOD. A reload caused by the load pin produces no pulse, and a held count does not repeat the pulse.
- R10: A register write (write enable high) stores data bit 5 as the software enable bit. The read port returns that bit in position 5 and zero in every other position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Load the period value (used only when ROUTE_LOAD=1) |
| en_i | input | 1 | Hardware count enable (used only when ROUTE_EN=1) |
| reg_we_i | input | 1 | Control-register write strobe |
| reg_wdata_i | input | 8 | Control-register write data; bit 5 is the software enable |
| reg_rdata_o | output | 8 | Control-register read data |
| count_o | output | 7 | Current count value |
| tc_o | output | 1 | Terminal count, combinational or registered by ALT_MODE |

## Verification
Some rules can be checked as a relation between one cycle and the next, and the assertions check those on every clock. These are the decrement step, the reload from zero, load priority, holding when not qualified, the value after reset, the register read-back mask and the placement of the terminal count in each mode. Other behaviour only shows over a whole scenario, and the bench covers it by driving a combinational-mode instance with every pin routed next to a registered-mode instance with no pins routed. Those scenarios show that an unrouted load or enable pin is ignored, that the registered pulse comes once per wrap and never after a load, and that a reset in the middle of a run clears the software enable.

// File: rtl/cnt7_pkg.sv
package cnt7_pkg;

  // Per-cycle command handed from the qualification logic to the count register
  typedef struct packed {
    logic load;   // force the period value into the count
    logic step;   // decrement, or reload when at zero
  } cnt_cmd_t;

  typedef enum logic {
    TC_REGISTERED = 1'b0,
    TC_AT_ZERO    = 1'b1
  } tc_mode_e;

endpackage

// File: rtl/cnt7_ctl_reg.sv
module cnt7_ctl_reg #(
  parameter int CTL_W     = 8,
  parameter int SW_EN_BIT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] rdata_o,
  output logic             sw_en_o
);

  logic sw_en_q;

  always_ff @(posedge clk) begin
    if (rst)       sw_en_q <= 1'b0;
    else if (we_i) sw_en_q <= wdata_i[SW_EN_BIT];
  end

  // Only the enable bit is implemented; the other positions read zero
  for (genvar i = 0; i < CTL_W; i++) begin : g_rd
    if (i == SW_EN_BIT) begin : g_live
      assign rdata_o[i] = sw_en_q;
    end else begin : g_zero
      assign rdata_o[i] = 1'b0;
    end
  end

  assign sw_en_o = sw_en_q;

endmodule

// File: rtl/cnt7_gate.sv
module cnt7_gate
  import cnt7_pkg::*;
#(
  parameter bit ROUTE_LOAD = 1'b0,
  parameter bit ROUTE_EN   = 1'b1
) (
  input  logic     ld_i,
  input  logic     en_i,
  input  logic     sw_en_i,
  output cnt_cmd_t cmd_o
);

  logic hw_en;
  logic ld_eff;

  if (ROUTE_EN) begin : g_en_routed
    assign hw_en = en_i;
  end else begin : g_en_tied
    assign hw_en = 1'b1;
  end

  if (ROUTE_LOAD) begin : g_ld_routed
    assign ld_eff = ld_i;
  end else begin : g_ld_tied
    assign ld_eff = 1'b0;
  end

  always_comb begin
    cmd_o.load = ld_eff;
    cmd_o.step = hw_en & sw_en_i;
  end

endmodule

// File: rtl/cnt7_core.sv
module cnt7_core
  import cnt7_pkg::*;
#(
  parameter int               CNT_W    = 7,
  parameter logic [CNT_W-1:0] INIT_VAL = '1,
  parameter logic [CNT_W-1:0] PERIOD   = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_cmd_t         cmd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             at_zero_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             zero;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (cmd_i.load)      cnt_d = PERIOD;
    else if (cmd_i.step) cnt_d = zero ? PERIOD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= INIT_VAL;
    else     cnt_q <= cnt_d;
  end

  assign count_o   = cnt_q;
  assign at_zero_o = zero;
  assign wrap_o    = cmd_i.step & ~cmd_i.load & zero;

endmodule

// File: rtl/cnt7_tc_gen.sv
module cnt7_tc_gen
  import cnt7_pkg::*;
#(
  parameter bit ALT_MODE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic at_zero_i,
  input  logic wrap_i,
  output logic tc_o
);

  if (tc_mode_e'(ALT_MODE) == TC_AT_ZERO) begin : g_comb
    assign tc_o = at_zero_i;
  end else begin : g_reg
    logic tc_q;
    always_ff @(posedge clk) begin
      if (rst) tc_q <= 1'b0;
      else     tc_q <= wrap_i;
    end
    assign tc_o = tc_q;
  end

endmodule

// File: rtl/cnt7_down_counter.sv
module cnt7_down_counter
  import cnt7_pkg::*;
#(
  parameter int               CNT_W      = 7,
  parameter int               CTL_W      = 8,
  parameter int               SW_EN_BIT  = 5,
  parameter logic [CNT_W-1:0] INIT_VAL   = '1,
  parameter logic [CNT_W-1:0] PERIOD     = '1,
  parameter bit               ALT_MODE   = 1'b1,
  parameter bit               ROUTE_LOAD = 1'b0,
  parameter bit               ROUTE_EN   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic             en_i,
  input  logic             reg_we_i,
  input  logic [CTL_W-1:0] reg_wdata_i,
  output logic [CTL_W-1:0] reg_rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);

  logic     sw_en;
  cnt_cmd_t cmd;
  logic     at_zero;
  logic     wrap;

  cnt7_ctl_reg #(
    .CTL_W    (CTL_W),
    .SW_EN_BIT(SW_EN_BIT)
  ) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .sw_en_o(sw_en)
  );

  cnt7_gate #(
    .ROUTE_LOAD(ROUTE_LOAD),
    .ROUTE_EN  (ROUTE_EN)
  ) u_gate (
    .ld_i   (ld_i),
    .en_i   (en_i),
    .sw_en_i(sw_en),
    .cmd_o  (cmd)
  );

  cnt7_core #(
    .CNT_W   (CNT_W),
    .INIT_VAL(INIT_VAL),
    .PERIOD  (PERIOD)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .cmd_i    (cmd),
    .count_o  (count_o),
    .at_zero_o(at_zero),
    .wrap_o   (wrap)
  );

  cnt7_tc_gen #(
    .ALT_MODE(ALT_MODE)
  ) u_tc (
    .clk      (clk),
    .rst      (rst),
    .at_zero_i(at_zero),
    .wrap_i   (wrap),
    .tc_o     (tc_o)
  );

endmodule

// File: rtl/cnt7_down_counter_chk.sv
module cnt7_down_counter_chk #(
  parameter int               CNT_W      = 7,
  parameter int               CTL_W      = 8,
  parameter int               SW_EN_BIT  = 5,
  parameter logic [CNT_W-1:0] INIT_VAL   = '1,
  parameter logic [CNT_W-1:0] PERIOD     = '1,
  parameter bit               ALT_MODE   = 1'b1,
  parameter bit               ROUTE_LOAD = 1'b0,
  parameter bit               ROUTE_EN   = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_i,
  input logic             en_i,
  input logic [CTL_W-1:0] reg_rdata_o,
  input logic [CNT_W-1:0] count_o,
  input logic             tc_o
);

  logic ld_eff;
  logic run;
  logic [CTL_W-1:0] other_mask;

  assign ld_eff     = ROUTE_LOAD && ld_i;
  assign run        = (ROUTE_EN ? en_i : 1'b1) && reg_rdata_o[SW_EN_BIT];
  assign other_mask = ~(CTL_W'(1) << SW_EN_BIT);

  assert_step_down_R1: assert property (@(posedge clk) disable iff (rst)
    (!ld_eff && run && count_o != '0) |=> (count_o == CNT_W'($past(count_o) - 1'b1)));

  assert_reset_value_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count_o == INIT_VAL && reg_rdata_o == '0 && (ALT_MODE || !tc_o)));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld_eff && !run) |=> $stable(count_o));

  assert_reload_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld_eff && run && count_o == '0) |=> (count_o == PERIOD));

  assert_load_wins_R5: assert property (@(posedge clk) disable iff (rst)
    ld_eff |=> (count_o == PERIOD));

  assert_tc_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ALT_MODE |-> (tc_o == (count_o == '0)));

  assert_tc_at_period_R9: assert property (@(posedge clk) disable iff (rst)
    (!ALT_MODE && tc_o) |-> (count_o == PERIOD));

  assert_tc_single_R9: assert property (@(posedge clk) disable iff (rst)
    (!ALT_MODE && tc_o && PERIOD != '0) |=> !tc_o);

  assert_rd_mask_R10: assert property (@(posedge clk) disable iff (rst)
    ((reg_rdata_o & other_mask) == '0));

endmodule

bind cnt7_down_counter cnt7_down_counter_chk #(
  .CNT_W     (CNT_W),
  .CTL_W     (CTL_W),
  .SW_EN_BIT (SW_EN_BIT),
  .INIT_VAL  (INIT_VAL),
  .PERIOD    (PERIOD),
  .ALT_MODE  (ALT_MODE),
  .ROUTE_LOAD(ROUTE_LOAD),
  .ROUTE_EN  (ROUTE_EN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ld_i       (ld_i),
  .en_i       (en_i),
  .reg_rdata_o(reg_rdata_o),
  .count_o    (count_o),
  .tc_o       (tc_o)
);

// File: tb/sim_cnt7_down_counter.sv
`timescale 1ns/1ps
module sim_cnt7_down_counter;

  localparam int P0 = 9;  // u0: zero-mode tc, load and enable routed
  localparam int I0 = 5;
  localparam int P1 = 6;  // u1: registered tc, nothing routed
  localparam int I1 = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld = 1'b0;
  logic       en = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd0, rd1;
  logic [6:0] cnt0, cnt1;
  logic       tc0, tc1;

  always #2 clk = ~clk;

  cnt7_down_counter #(
    .INIT_VAL(7'(I0)), .PERIOD(7'(P0)),
    .ALT_MODE(1'b1), .ROUTE_LOAD(1'b1), .ROUTE_EN(1'b1)
  ) u0 (
    .clk(clk), .rst(rst), .ld_i(ld), .en_i(en),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rd0),
    .count_o(cnt0), .tc_o(tc0)
  );

  cnt7_down_counter #(
    .INIT_VAL(7'(I1)), .PERIOD(7'(P1)),
    .ALT_MODE(1'b0), .ROUTE_LOAD(1'b0), .ROUTE_EN(1'b0)
  ) u1 (
    .clk(clk), .rst(rst), .ld_i(ld), .en_i(en),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rd1),
    .count_o(cnt1), .tc_o(tc1)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R2 reset";
  bit    done   = 1'b0;

  // Behavioural reference model, updated at every rising edge
  int m_c0 = I0, m_c1 = I1;
  bit m_t1 = 0, m_sw = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_c0 = I0; m_c1 = I1; m_t1 = 0; m_sw = 0;
    end else begin
      if (ld)              m_c0 = P0;
      else if (en && m_sw) m_c0 = (m_c0 == 0) ? P0 : m_c0 - 1;
      m_t1 = m_sw && (m_c1 == 0);
      if (m_sw)            m_c1 = (m_c1 == 0) ? P1 : m_c1 - 1;
      if (we)              m_sw = wdata[5];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(cnt0 == 7'(m_c0), {phase, " u0 count"}, int'(cnt0), m_c0);
      check(tc0 == (m_c0 == 0), {phase, " u0 tc R8"}, int'(tc0), int'(m_c0 == 0));
      check(cnt1 == 7'(m_c1), {phase, " u1 count"}, int'(cnt1), m_c1);
      check(tc1 == m_t1, {phase, " u1 tc R9"}, int'(tc1), int'(m_t1));
      check(rd0 == {2'b00, m_sw, 5'b0}, {phase, " u0 reg R10"}, int'(rd0), int'(m_sw) * 32);
      check(rd1 == {2'b00, m_sw, 5'b0}, {phase, " u1 reg R10"}, int'(rd1), int'(m_sw) * 32);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = 8'h00;
  endtask

  initial begin
    cycles(3);
    rst = 1'b0;
    // R2: state right after reset
    check(cnt0 == 7'(I0) && rd0 == 8'h00, "R2 u0 reset state", int'(cnt0), I0);
    check(cnt1 == 7'(I1) && !tc1, "R2 u1 reset state", int'(cnt1), I1);

    phase = "R3 hw enable without sw bit";
    en = 1'b1; cycles(4);

    phase = "R10 write all ones";
    wr(8'hFF);
    check(rd0 == 8'h20, "R10 readback mask", int'(rd0), 32);
    phase = "R3 sw bit cleared by write";
    wr(8'hDF); cycles(3);

    phase = "R1 R4 R8 R9 running";
    wr(8'h20); cycles(25);

    phase = "R3 R7 hw enable low";
    en = 1'b0; cycles(9);

    phase = "R5 R6 load pulse";
    en = 1'b1; cycles(2);
    @(negedge clk); ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    cycles(3);

    phase = "R5 load while disabled";
    en = 1'b0;
    @(negedge clk); ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    cycles(3);

    phase = "R4 R5 R9 load at zero";
    en = 1'b1;
    wait (cnt0 == 7'd0);
    ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    cycles(12);

    phase = "R2 reset mid run";
    @(negedge clk); rst = 1'b1;
    cycles(2); rst = 1'b0;
    check(rd0 == 8'h00, "R2 sw bit cleared", int'(rd0), 0);
    cycles(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule